// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the synchronous command front end of a NOR-style flash device. It watches the asynchronous bus strobes (chip enable, write enable, latch enable, output enable) by sampling them on the system clock, recognises bus write cycles, and decodes the instruction byte that each write carries. A read-mode register selects what the device returns on a read: array contents, identifier data (electronic signature and block protection status, both reached through one instruction), the status register, or query data.

Two instructions need two write cycles. Block erase takes a setup write and then a confirm write that carries the block address. Write-to-buffer-and-program takes a setup write and then a write that carries the target address and the word count. When a sequence completes, the block sends a one-cycle start pulse with the captured address and count to an external erase/program engine. A malformed second cycle aborts the sequence and raises a sequence-error flag, which a clear-status instruction removes.

Top module: `fci_top`

## Requirements
- R1: After reset, and after a reset in the middle of a two-cycle sequence, the read mode is array (code 0), the sequence-error flag is 0, no start pulse is issued, and the next write is decoded as a first cycle.
- R2: A write is recognised only when chip enable, write enable and latch enable have all been sampled low together while output enable was sampled high; strobe activity with output enable low or latch enable held high changes nothing.
- R3: A write is committed on the first rising edge of chip enable or write enable; its data is the last value sampled while both were low, and data changed after that edge has no effect.
- R4: The write address is the last value sampled while chip, write and latch enable were all low, so it freezes at the first rising edge among the three.
- R5: Instruction byte din[7:0] selects the read mode: 8'hFF array (0), 8'h90 identifier (1), 8'h70 status (2), 8'h98 query (3); din bits above 7 are ignored for instruction decoding.
- R6: 8'h50 is a one-cycle instruction that clears the sequence-error flag and leaves the read mode unchanged.
- R7: 8'h20 followed by a write of 8'hD0 issues a one-cycle erase start pulse with start_addr equal to the second write's address and sets the read mode to status.
- R8: 8'hE8 followed by a write whose whole data word N satisfies 1 <= N <= BUF_WORDS (default 32) issues a one-cycle program start pulse with start_addr equal to that write's address and start_count equal to N, and sets the read mode to status.
- R9: A second cycle that is not 8'hD0 after 8'h20, or a count of 0 or above BUF_WORDS after 8'hE8, issues no pulse, sets the sequence-error flag, sets the read mode to status and returns to first-cycle decoding.
- R10: A first-cycle byte that is none of the codes above leaves read mode, error flag and sequence state unchanged and issues no pulse.
- R11: With the default single input stage, the read mode, error flag and start pulses change on the second rising clock edge after the committing strobe rises, and each start pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| oe_n | input | 1 | Output enable, active low (must be high for a write) |
| le_n | input | 1 | Latch enable strobe, active low |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| rd_mode | output | 2 | Read mode: 0 array, 1 identifier, 2 status, 3 query |
| seq_err | output | 1 | Sequence-error status flag |
| start_erase | output | 1 | One-cycle erase start pulse |
| start_prog | output | 1 | One-cycle program start pulse |
| start_addr | output | ADDR_W | Address handed to the engine |
| start_count | output | CNT_W | Word count handed to the engine |

## Verification
Every result of a write is due on the second rising clock edge after the committing strobe is driven high: one edge registers the strobe, the next registers the decoded outcome. The bench drives strobes on falling edges and samples outputs on the falling edge after the first and after the second rising edge, requiring the old value at the first and the new value at the second, so a result that arrives a cycle early or late is reported. Start pulses are also counted on every falling edge across each transfer, which catches extra or stretched pulses outside the sampled cycle.

// File: rtl/fci_pkg.sv
package fci_pkg;

   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_IDENT  = 2'd1,
      MODE_STATUS = 2'd2,
      MODE_QUERY  = 2'd3
   } rd_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE       = 2'd0,
      SQ_ERASE_CONF = 2'd1,
      SQ_BUF_COUNT  = 2'd2
   } seq_state_e;

   localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
   localparam logic [7:0] OP_IDENT      = 8'h90;
   localparam logic [7:0] OP_STATUS     = 8'h70;
   localparam logic [7:0] OP_QUERY      = 8'h98;
   localparam logic [7:0] OP_CLR_STATUS = 8'h50;
   localparam logic [7:0] OP_ERASE      = 8'h20;
   localparam logic [7:0] OP_BUF_PROG   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM    = 8'hD0;

   // strobe vector bit positions
   localparam int unsigned S_CE     = 0;
   localparam int unsigned S_WE     = 1;
   localparam int unsigned S_LE     = 2;
   localparam int unsigned S_OE     = 3;
   localparam int unsigned N_STROBE = 4;

endpackage

// File: rtl/fci_sampler.sv
module fci_sampler
   import fci_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned IN_STAGES = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STROBE-1:0] strobe_raw,
   input  logic [ADDR_W-1:0]   addr_raw,
   input  logic [DATA_W-1:0]   data_raw,
   output logic [N_STROBE-1:0] strobe_s,
   output logic [N_STROBE-1:0] strobe_p,
   output logic [ADDR_W-1:0]   addr_s,
   output logic [DATA_W-1:0]   data_s
);
   localparam int unsigned BUS_W = N_STROBE + ADDR_W + DATA_W;
   localparam logic [BUS_W-1:0] IDLE_WORD = {{N_STROBE{1'b1}}, {(ADDR_W+DATA_W){1'b0}}};

   logic [BUS_W-1:0] pipe_q [IN_STAGES];
   logic [N_STROBE-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < IN_STAGES; i++) pipe_q[i] <= IDLE_WORD;
         prev_q <= '1;
      end else begin
         pipe_q[0] <= {strobe_raw, addr_raw, data_raw};
         for (int i = 1; i < IN_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
         prev_q <= strobe_s;
      end
   end

   assign {strobe_s, addr_s, data_s} = pipe_q[IN_STAGES-1];
   assign strobe_p = prev_q;

endmodule

// File: rtl/fci_latch.sv
module fci_latch
   import fci_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STROBE-1:0] strobe_s,
   input  logic [N_STROBE-1:0] strobe_p,
   input  logic [ADDR_W-1:0]   addr_s,
   input  logic [DATA_W-1:0]   data_s,
   output logic                commit,
   output logic [ADDR_W-1:0]   cap_addr,
   output logic [DATA_W-1:0]   cap_data
);
   logic win_full, win_data, rise_ce, rise_we, armed_q;

   // full window: chip, write and latch enable low, output enable high
   assign win_data = !strobe_s[S_CE] && !strobe_s[S_WE] && strobe_s[S_OE];
   assign win_full = win_data && !strobe_s[S_LE];
   assign rise_ce  = strobe_s[S_CE] && !strobe_p[S_CE];
   assign rise_we  = strobe_s[S_WE] && !strobe_p[S_WE];
   assign commit   = armed_q && (rise_ce || rise_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         if (win_full)                   armed_q <= 1'b1;
         else if (commit || !strobe_s[S_OE]) armed_q <= 1'b0;
         if (win_full) cap_addr <= addr_s;
         if (win_data) cap_data <= data_s;
      end
   end

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_full |=> $stable(cap_addr));

   // R3
   commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(win_data));

endmodule

// File: rtl/fci_seq.sv
module fci_seq
   import fci_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BUF_WORDS = 32,
   parameter int unsigned CNT_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [ADDR_W-1:0] cap_addr,
   input  logic [DATA_W-1:0] cap_data,
   output rd_mode_e          rd_mode,
   output logic              seq_err,
   output logic              start_erase,
   output logic              start_prog,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  start_count
);
   seq_state_e state_q;
   logic [7:0] op;
   logic       cnt_ok;

   assign op     = cap_data[7:0];
   assign cnt_ok = (cap_data != '0) && (cap_data <= DATA_W'(BUF_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         rd_mode     <= MODE_ARRAY;
         seq_err     <= 1'b0;
         start_erase <= 1'b0;
         start_prog  <= 1'b0;
         start_addr  <= '0;
         start_count <= '0;
      end else begin
         start_erase <= 1'b0;
         start_prog  <= 1'b0;
         if (commit) begin
            unique case (state_q)
               SQ_IDLE: begin
                  case (op)
                     OP_READ_ARRAY: rd_mode <= MODE_ARRAY;
                     OP_IDENT:      rd_mode <= MODE_IDENT;
                     OP_STATUS:     rd_mode <= MODE_STATUS;
                     OP_QUERY:      rd_mode <= MODE_QUERY;
                     OP_CLR_STATUS: seq_err <= 1'b0;
                     OP_ERASE:      state_q <= SQ_ERASE_CONF;
                     OP_BUF_PROG:   state_q <= SQ_BUF_COUNT;
                     default:       ;
                  endcase
               end
               SQ_ERASE_CONF: begin
                  state_q <= SQ_IDLE;
                  rd_mode <= MODE_STATUS;
                  if (op == OP_CONFIRM) begin
                     start_erase <= 1'b1;
                     start_addr  <= cap_addr;
                     start_count <= '0;
                  end else begin
                     seq_err <= 1'b1;
                  end
               end
               SQ_BUF_COUNT: begin
                  state_q <= SQ_IDLE;
                  rd_mode <= MODE_STATUS;
                  if (cnt_ok) begin
                     start_prog  <= 1'b1;
                     start_addr  <= cap_addr;
                     start_count <= CNT_W'(cap_data);
                  end else begin
                     seq_err <= 1'b1;
                  end
               end
               default: state_q <= SQ_IDLE;
            endcase
         end
      end
   end

   // R11
   one_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_erase, start_prog}));

   // R11
   erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_erase |=> !start_erase);

   // R11
   prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_prog |=> !start_prog);

   // R8
   prog_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_prog |-> (start_count != '0) && (start_count <= CNT_W'(BUF_WORDS)));

   // R9
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> (rd_mode == MODE_STATUS) && $past(state_q != SQ_IDLE));

   // R6
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit && state_q == SQ_IDLE && op == OP_CLR_STATUS) |-> !seq_err);

endmodule

// File: rtl/fci_top.sv
module fci_top
   import fci_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BUF_WORDS = 32,
   parameter int unsigned IN_STAGES = 1,
   localparam int unsigned CNT_W    = $clog2(BUF_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              le_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [1:0]        rd_mode,
   output logic              seq_err,
   output logic              start_erase,
   output logic              start_prog,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  start_count
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("fci_top: DATA_W must hold an 8-bit instruction");
      end
      if (IN_STAGES < 1) begin : g_bad_stages
         $error("fci_top: IN_STAGES must be at least 1");
      end
      if (BUF_WORDS < 1 || BUF_WORDS >= (64'd1 << DATA_W)) begin : g_bad_buf
         $error("fci_top: BUF_WORDS must fit the data bus and be nonzero");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("fci_top: ADDR_W must be nonzero");
      end
   endgenerate

   logic [N_STROBE-1:0] strobe_raw, strobe_s, strobe_p;
   logic [ADDR_W-1:0]   addr_s, cap_addr;
   logic [DATA_W-1:0]   data_s, cap_data;
   logic                commit;
   rd_mode_e            mode;

   always_comb begin
      strobe_raw        = '1;
      strobe_raw[S_CE]  = ce_n;
      strobe_raw[S_WE]  = we_n;
      strobe_raw[S_LE]  = le_n;
      strobe_raw[S_OE]  = oe_n;
   end

   fci_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_STAGES(IN_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n),
      .strobe_raw(strobe_raw), .addr_raw(addr), .data_raw(din),
      .strobe_s(strobe_s), .strobe_p(strobe_p), .addr_s(addr_s), .data_s(data_s)
   );

   fci_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .strobe_s(strobe_s), .strobe_p(strobe_p), .addr_s(addr_s), .data_s(data_s),
      .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data)
   );

   fci_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data),
      .rd_mode(mode), .seq_err(seq_err),
      .start_erase(start_erase), .start_prog(start_prog),
      .start_addr(start_addr), .start_count(start_count)
   );

   assign rd_mode = mode;

   // R1
   reset_mode_chk: assert property (@(posedge clk)
      !rst_n |=> (rd_mode == MODE_ARRAY) || rst_n);

endmodule

// File: tb/tb_fci_top.sv
module tb_fci_top;
   localparam int unsigned ADDR_W = 24;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned CNT_W  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, le_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] din = '0;
   logic [1:0] rd_mode;
   logic seq_err, start_erase, start_prog;
   logic [ADDR_W-1:0] start_addr;
   logic [CNT_W-1:0] start_count;

   always #5 clk = ~clk;

   fci_top dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .le_n(le_n),
      .addr(addr), .din(din), .rd_mode(rd_mode), .seq_err(seq_err),
      .start_erase(start_erase), .start_prog(start_prog),
      .start_addr(start_addr), .start_count(start_count)
   );

   int n_cmp = 0, n_bad = 0, pulses = 0;
   logic prev_ers = 1'b0, prev_prg = 1'b0;
   logic e_ers, e_prg, d_ers, d_prg, d_err;
   logic [1:0] e_mode, d_mode;
   int p_delta;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   // pulse monitor: count pulses and flag any pulse longer than one cycle (R11)
   always @(negedge clk) begin
      if (rst_n) begin
         pulses <= pulses + int'(start_erase) + int'(start_prog);
         if ((start_erase && prev_ers) || (start_prog && prev_prg)) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 pulse width: got 2+ cycles expected 1");
         end
      end
      prev_ers <= start_erase;
      prev_prg <= start_prog;
   end

   task automatic xfer(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] a2,
                       input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] d2,
                       input bit ce_first, input logic oe_v, input logic le_v);
      int p0;
      @(negedge clk);
      p0 = pulses;
      ce_n = 1'b0; we_n = 1'b0; le_n = le_v; oe_n = oe_v; addr = a; din = d;
      repeat (3) @(negedge clk);
      le_n = 1'b1; addr = a2; din = d2;
      repeat (3) @(negedge clk);
      if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
      @(posedge clk); @(negedge clk);
      e_ers = start_erase; e_prg = start_prog; e_mode = rd_mode;
      @(posedge clk); @(negedge clk);
      d_ers = start_erase; d_prg = start_prog; d_mode = rd_mode; d_err = seq_err;
      if (ce_first) begin
         din = ~d2;
         @(negedge clk);
         we_n = 1'b1;
      end else begin
         ce_n = 1'b1;
      end
      repeat (3) @(negedge clk);
      oe_n = 1'b1; le_n = 1'b1;
      repeat (2) @(negedge clk);
      p_delta = pulses - p0;
   endtask

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      logic [1:0]        m;
      logic              e;
      logic              er;
      logic              pg;
      logic [ADDR_W-1:0] sa;
      logic [CNT_W-1:0]  sc;
      logic [3:0]        r;
   } vec_t;

   localparam string RQ [12] = '{"--", "R1", "R2", "R3", "R4", "R5", "R6",
                                 "R7", "R8", "R9", "R10", "R11"};
   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{24'h000000, 16'h00FF, 2'd0, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h0090, 2'd1, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h0098, 2'd3, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h0070, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h0020, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd7},
      '{24'h120000, 16'h00D0, 2'd2, 1'b0, 1'b1, 1'b0, 24'h120000, 6'd0, 4'd7},
      '{24'h000000, 16'h00E8, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd8},
      '{24'h004000, 16'h0004, 2'd2, 1'b0, 1'b0, 1'b1, 24'h004000, 6'd4, 4'd8},
      '{24'h000000, 16'h0020, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd9},
      '{24'h000000, 16'h0077, 2'd2, 1'b1, 1'b0, 1'b0, 24'h0, 6'd0, 4'd9},
      '{24'h000000, 16'h0090, 2'd1, 1'b1, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h0050, 2'd1, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd6},
      '{24'h000000, 16'h00E8, 2'd1, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd8},
      '{24'h000000, 16'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 24'h0, 6'd0, 4'd9},
      '{24'h000000, 16'h0050, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd6},
      '{24'h000000, 16'h0012, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd10},
      '{24'h000000, 16'h00E8, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd8},
      '{24'h3FFFFE, 16'h0020, 2'd2, 1'b0, 1'b0, 1'b1, 24'h3FFFFE, 6'd32, 4'd8},
      '{24'h000000, 16'h00E8, 2'd2, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd8},
      '{24'h000000, 16'h0021, 2'd2, 1'b1, 1'b0, 1'b0, 24'h0, 6'd0, 4'd9},
      '{24'h000000, 16'h00FF, 2'd0, 1'b1, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h5A90, 2'd1, 1'b1, 1'b0, 1'b0, 24'h0, 6'd0, 4'd5},
      '{24'h000000, 16'h0050, 2'd1, 1'b0, 1'b0, 1'b0, 24'h0, 6'd0, 4'd6}
   };

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", "mode in reset", rd_mode, 0);
      chk("R1", "err in reset", seq_err, 0);
      chk("R1", "pulses in reset", {start_erase, start_prog}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i].a, VEC[i].a, VEC[i].d, VEC[i].d, 1'b0, 1'b1, 1'b0);
         chk(RQ[VEC[i].r], "rd_mode", d_mode, VEC[i].m);
         chk(RQ[VEC[i].r], "seq_err", d_err, VEC[i].e);
         chk(RQ[VEC[i].r], "start_erase", d_ers, VEC[i].er);
         chk(RQ[VEC[i].r], "start_prog", d_prg, VEC[i].pg);
         chk(RQ[VEC[i].r], "pulse count", p_delta, int'(VEC[i].er) + int'(VEC[i].pg));
         if (VEC[i].er || VEC[i].pg) begin
            chk(RQ[VEC[i].r], "start_addr", start_addr, VEC[i].sa);
            chk(RQ[VEC[i].r], "start_count", start_count, VEC[i].sc);
            // R11: not one cycle early
            chk("R11", "early pulse", {e_ers, e_prg}, 0);
         end
      end

      // R11: mode change lands exactly on the second edge
      xfer(24'h0, 24'h0, 16'h0098, 16'h0098, 1'b0, 1'b1, 1'b0);
      chk("R11", "mode one cycle early", e_mode, 1);
      chk("R11", "mode on due cycle", d_mode, 3);

      // R2: output enable low blocks the write
      xfer(24'h0, 24'h0, 16'h0070, 16'h0070, 1'b0, 1'b0, 1'b0);
      chk("R2", "oe low ignored", rd_mode, 3);
      // R2: latch enable held high blocks the write
      xfer(24'h0, 24'h0, 16'h0090, 16'h0090, 1'b0, 1'b1, 1'b1);
      chk("R2", "le high ignored", rd_mode, 3);

      // R3: chip enable rising first commits; later data change ignored
      xfer(24'h0, 24'h0, 16'h0090, 16'h0090, 1'b1, 1'b1, 1'b0);
      chk("R3", "ce-first commit", d_mode, 1);
      chk("R3", "data after commit ignored", rd_mode, 1);

      // R4: address frozen at latch enable rise
      xfer(24'h0, 24'h0, 16'h0020, 16'h0020, 1'b0, 1'b1, 1'b0);
      xfer(24'h0A0000, 24'h0B0000, 16'h00D0, 16'h00D0, 1'b0, 1'b1, 1'b0);
      chk("R4", "erase pulse", p_delta, 1);
      chk("R4", "frozen address", start_addr, 24'h0A0000);

      // R3: data changed after latch enable rise, before write enable rise, is used
      xfer(24'h0, 24'h0, 16'h00E8, 16'h00E8, 1'b0, 1'b1, 1'b0);
      xfer(24'h000100, 24'h000100, 16'h0005, 16'h0007, 1'b0, 1'b1, 1'b0);
      chk("R3", "latest data count", start_count, 7);

      // R1: reset in the middle of a two-cycle sequence
      xfer(24'h0, 24'h0, 16'h0020, 16'h0020, 1'b0, 1'b1, 1'b0);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "mode after reset", rd_mode, 0);
      rst_n = 1'b1;
      xfer(24'h0, 24'h0, 16'h00D0, 16'h00D0, 1'b0, 1'b1, 1'b0);
      chk("R1", "no erase after reset", p_delta, 0);
      chk("R1", "err after reset", seq_err, 0);
      chk("R10", "unknown code keeps mode", rd_mode, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule